// File: doc/BRIEF.md
# Firmware-Mode Trap Entry Sequencer

This block moves a processor core between normal execution and a privileged firmware mode. The core presents the trap requests it sees each cycle: interrupt, arithmetic fault, unimplemented opcode, memory fault, firmware-call instruction, instruction-translation miss and data-translation miss. The block picks one request by a fixed priority. At the next clock edge it saves the program counter and the previous firmware-mode flag, enters firmware mode, and issues a one-cycle redirect to a physical address. That address is the firmware base plus a hard-wired slot offset chosen by the cause.

A dedicated return instruction, legal only in firmware mode, restores the program counter and the firmware-mode flag from the saved copies. The block also decodes the five privileged-only operations, which are move-to-special, move-from-special, physical load, physical store and return. Outside firmware mode each of them is turned into an unimplemented-instruction trap. The firmware-mode flag drives the translation-enable and interrupt-allow outputs that the fetch and interrupt logic read. The user/kernel mode flag is held elsewhere and is not changed by this block.

Top module: `fwm_trap_seq`

## Requirements
- R1: While reset is held and after it is released, the outputs are as follows until the first request: `fw_mode_o`=1 (parameter `RST_FW`), `xlate_on_o`=0, `irq_allow_o`=0, `redirect_o`=0, `cause_o`=0, `target_o`=0, `saved_pc_o`=0 and `saved_fw_o`=0.
- R2: A trap accepted at a clock edge has the following effects from that edge on. `saved_pc_o` holds the `pc_i` of that cycle, `saved_fw_o` holds the previous `fw_mode_o`, and `fw_mode_o` is 1. While `fw_mode_o` is 1, `xlate_on_o` and `irq_allow_o` are 0, and both are 1 otherwise.
- R3: On a trap, `redirect_o` is high for exactly one cycle and `target_o` = `fw_base_i` + (code << `SLOT_SH`). The codes on `cause_o` are: unimplemented 1, arithmetic 2, memory fault 3, firmware call 4, instruction miss 5, data miss in normal mode 6, data miss in firmware mode 7, interrupt 8.
- R4: When several requests are present, the winner is the first one in this order: unimplemented (including an illegal privileged op), arithmetic, memory fault, firmware call, instruction miss, data miss, interrupt.
- R5: An interrupt is taken only when `irq_i`, `irq_en_i` and not `fw_mode_o` all hold. Otherwise it causes no redirect.
- R6: With `instr_valid_i` high, `priv_op_i` codes 1 (move-to), 2 (move-from), 3 (physical load), 4 (physical store) and 5 (return) are privileged. Outside firmware mode they raise code 1. Inside it they raise no trap, and `priv_ok_o` is high in the same cycle. Codes 0, 6 and 7 have no effect.
- R7: A return (op 5) in firmware mode with no trap pending pulses `redirect_o` with `cause_o`=15 and `target_o`=`saved_pc_o`, and sets `fw_mode_o` to `saved_fw_o`. The saved registers are unchanged by it.
- R8: A data miss taken in firmware mode uses code 7, and an instruction miss uses code 5 in either mode.
- R9: A trap that coincides with a return wins. The return is dropped, and the saved registers capture the trap state.
- R10: In a cycle with no request, `redirect_o` and `cause_o` go to 0 at the next edge, and `fw_mode_o`, `saved_pc_o` and `saved_fw_o` are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | PC_W | PC of the instruction being retired or trapped |
| fw_base_i | input | PC_W | Physical base of the firmware image |
| instr_valid_i | input | 1 | `priv_op_i` is meaningful this cycle |
| priv_op_i | input | 3 | Privileged-op class (see R6) |
| unimpl_i | input | 1 | Unimplemented opcode request |
| arith_i | input | 1 | Arithmetic fault request |
| mem_fault_i | input | 1 | Memory fault request |
| fw_call_i | input | 1 | Firmware-call instruction request |
| itb_miss_i | input | 1 | Instruction translation miss |
| dtb_miss_i | input | 1 | Data translation miss |
| irq_i | input | 1 | Pending interrupt |
| irq_en_i | input | 1 | Interrupt enable flags permit delivery |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| target_o | output | PC_W | Redirect address |
| cause_o | output | 4 | Code of the redirect (R3, 15 for return) |
| fw_mode_o | output | 1 | Firmware-mode flag |
| xlate_on_o | output | 1 | Instruction fetch uses translation |
| irq_allow_o | output | 1 | Interrupt logic may deliver |
| priv_ok_o | output | 1 | Privileged op may execute this cycle |
| saved_pc_o | output | PC_W | Saved program counter |
| saved_fw_o | output | 1 | Saved firmware-mode flag |

## Verification
The bench drives a stack of simultaneous requests and removes the winner one at a time. A priority encoder with two entries swapped would therefore report the wrong cause code. It raises an interrupt while in firmware mode and with enables clear. If the mask were missing, the bench would see a redirect that should not happen. It also issues each privileged op on both sides of the mode boundary, returns with a saved firmware flag of both values, nests a data miss inside firmware mode, and pairs a fault with a return. A design that restored the wrong flag, reused the normal data-miss slot, or let the return beat the fault would show a wrong `fw_mode_o`, code or target.

// File: rtl/fwt_pkg.sv
package fwt_pkg;

   localparam int CODE_W = 4;
   localparam int N_SRC  = 7;

   typedef enum logic [CODE_W-1:0] {
      CZ_NONE   = 4'd0,
      CZ_UNIMPL = 4'd1,
      CZ_ARITH  = 4'd2,
      CZ_MEMF   = 4'd3,
      CZ_CALL   = 4'd4,
      CZ_ITB    = 4'd5,
      CZ_DTB    = 4'd6,
      CZ_DTB_FW = 4'd7,
      CZ_IRQ    = 4'd8,
      CZ_RET    = 4'd15
   } cause_e;

   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_MTSR = 3'd1,
      OP_MFSR = 3'd2,
      OP_PLD  = 3'd3,
      OP_PST  = 3'd4,
      OP_RET  = 3'd5
   } priv_op_e;

   // Priority index (0 = highest) to trap code.
   function automatic cause_e src_code(input int idx, input logic in_fw);
      case (idx)
         0:       return CZ_UNIMPL;
         1:       return CZ_ARITH;
         2:       return CZ_MEMF;
         3:       return CZ_CALL;
         4:       return CZ_ITB;
         5:       return in_fw ? CZ_DTB_FW : CZ_DTB;
         6:       return CZ_IRQ;
         default: return CZ_NONE;
      endcase
   endfunction

endpackage

// File: rtl/fwt_prio.sv
module fwt_prio #(
   parameter int N = 7
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);

   if (N < 2) begin : g_bad_n
      $error("fwt_prio: N must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_grant
      if (i == 0) begin : g_top
         assign grant[i] = req[i];
      end else begin : g_rest
         assign grant[i] = req[i] & ~(|req[i-1:0]);
      end
   end

   assign any = |req;

endmodule

// File: rtl/fwt_vec.sv
module fwt_vec
   import fwt_pkg::*;
#(
   parameter int PC_W         = 32,
   parameter int SLOT_SH      = 8,
   parameter bit ALIGNED_BASE = 1'b0
) (
   input  logic [PC_W-1:0]   base,
   input  cause_e            code,
   output logic [PC_W-1:0]   target
);

   localparam int TOP_LO = SLOT_SH + CODE_W;

   if (PC_W < TOP_LO + 1) begin : g_bad_w
      $error("fwt_vec: PC_W too small for SLOT_SH and code width");
   end

   if (ALIGNED_BASE) begin : g_concat
      // Base is assumed aligned to the full slot table: no carry chain.
      assign target = {base[PC_W-1:TOP_LO], code, {SLOT_SH{1'b0}}};
   end else begin : g_add
      assign target = base + (PC_W'(code) << SLOT_SH);
   end

endmodule

// File: rtl/fwt_gate.sv
module fwt_gate
   import fwt_pkg::*;
(
   input  logic       valid,
   input  logic [2:0] op,
   input  logic       in_fw,
   output logic       priv_ok,
   output logic       illegal,
   output logic       ret_req
);

   logic is_priv;

   assign is_priv = valid && (op >= 3'(OP_MTSR)) && (op <= 3'(OP_RET));
   assign priv_ok = is_priv && in_fw;
   assign illegal = is_priv && !in_fw;
   assign ret_req = priv_ok && (op == 3'(OP_RET));

endmodule

// File: rtl/fwm_trap_seq.sv
module fwm_trap_seq
   import fwt_pkg::*;
#(
   parameter int PC_W         = 32,
   parameter int SLOT_SH      = 8,
   parameter bit ALIGNED_BASE = 1'b0,
   parameter bit RST_FW       = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] pc_i,
   input  logic [PC_W-1:0] fw_base_i,
   input  logic            instr_valid_i,
   input  logic [2:0]      priv_op_i,
   input  logic            unimpl_i,
   input  logic            arith_i,
   input  logic            mem_fault_i,
   input  logic            fw_call_i,
   input  logic            itb_miss_i,
   input  logic            dtb_miss_i,
   input  logic            irq_i,
   input  logic            irq_en_i,
   output logic            redirect_o,
   output logic [PC_W-1:0] target_o,
   output logic [3:0]      cause_o,
   output logic            fw_mode_o,
   output logic            xlate_on_o,
   output logic            irq_allow_o,
   output logic            priv_ok_o,
   output logic [PC_W-1:0] saved_pc_o,
   output logic            saved_fw_o
);

   if (SLOT_SH < 2) begin : g_bad_slot
      $error("fwm_trap_seq: SLOT_SH must be at least 2");
   end

   logic              fw_q, sfw_q, redir_q;
   logic [PC_W-1:0]   spc_q, tgt_q;
   cause_e            cause_q, code;
   logic [N_SRC-1:0]  req, grant;
   logic              any_trap, illegal, ret_req, take_ret;
   logic [PC_W-1:0]   vec_tgt;

   fwt_gate u_gate (
      .valid   (instr_valid_i),
      .op      (priv_op_i),
      .in_fw   (fw_q),
      .priv_ok (priv_ok_o),
      .illegal (illegal),
      .ret_req (ret_req)
   );

   // Index 0 is the highest priority.
   assign req = {irq_i & irq_en_i & ~fw_q,
                 dtb_miss_i,
                 itb_miss_i,
                 fw_call_i,
                 mem_fault_i,
                 arith_i,
                 unimpl_i | illegal};

   fwt_prio #(.N(N_SRC)) u_prio (
      .req   (req),
      .grant (grant),
      .any   (any_trap)
   );

   always_comb begin
      code = CZ_NONE;
      for (int i = 0; i < N_SRC; i++) begin
         if (grant[i]) code = src_code(i, fw_q);
      end
   end

   fwt_vec #(.PC_W(PC_W), .SLOT_SH(SLOT_SH), .ALIGNED_BASE(ALIGNED_BASE)) u_vec (
      .base   (fw_base_i),
      .code   (code),
      .target (vec_tgt)
   );

   assign take_ret = ret_req & ~any_trap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fw_q    <= RST_FW;
         sfw_q   <= 1'b0;
         spc_q   <= '0;
         tgt_q   <= '0;
         redir_q <= 1'b0;
         cause_q <= CZ_NONE;
      end else if (any_trap) begin
         spc_q   <= pc_i;
         sfw_q   <= fw_q;
         fw_q    <= 1'b1;
         tgt_q   <= vec_tgt;
         redir_q <= 1'b1;
         cause_q <= code;
      end else if (take_ret) begin
         fw_q    <= sfw_q;
         tgt_q   <= spc_q;
         redir_q <= 1'b1;
         cause_q <= CZ_RET;
      end else begin
         redir_q <= 1'b0;
         cause_q <= CZ_NONE;
      end
   end

   assign redirect_o  = redir_q;
   assign target_o    = tgt_q;
   assign cause_o     = cause_q;
   assign fw_mode_o   = fw_q;
   assign xlate_on_o  = ~fw_q;
   assign irq_allow_o = ~fw_q;
   assign saved_pc_o  = spc_q;
   assign saved_fw_o  = sfw_q;

   // R2: entry captures PC and prior mode, and lands in firmware mode
   p_entry_save_r2: assert property (@(posedge clk) disable iff (!rst_n)
      any_trap |=> (saved_pc_o == $past(pc_i)) && (saved_fw_o == $past(fw_mode_o)) && fw_mode_o);

   // R5: no interrupt redirect when masked or already in firmware mode
   p_irq_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_mode_o || !irq_en_i) |=> !(redirect_o && (cause_o == 4'(CZ_IRQ))));

   // R6: privileged op outside firmware mode traps as unimplemented
   p_priv_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid_i && (priv_op_i >= 3'd1) && (priv_op_i <= 3'd5) && !fw_mode_o)
      |=> (redirect_o && (cause_o == 4'(CZ_UNIMPL))));

   // R7: return restores PC and mode from saved copies
   p_ret_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take_ret |=> (fw_mode_o == $past(saved_fw_o)) && (target_o == $past(saved_pc_o))
                   && $stable(saved_pc_o));

   // R8: firmware-mode data-miss slot only used from firmware mode
   p_dtb_fw_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dtb_miss_i && !(|grant[4:0]) && fw_mode_o) |=> (cause_o == 4'(CZ_DTB_FW)));

endmodule

// File: tb/fwm_trap_seq_tb.sv
module fwm_trap_seq_tb;

   localparam int PC_W = 32;
   localparam int SH   = 8;
   localparam logic [PC_W-1:0] BASE = 32'h0001_0000;
   localparam int NV = 36;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst_n;
   logic [PC_W-1:0] pc_i;
   logic            instr_valid_i;
   logic [2:0]      priv_op_i;
   logic            unimpl_i, arith_i, mem_fault_i, fw_call_i;
   logic            itb_miss_i, dtb_miss_i, irq_i, irq_en_i;
   logic            redirect_o, fw_mode_o, xlate_on_o, irq_allow_o, priv_ok_o, saved_fw_o;
   logic [PC_W-1:0] target_o, saved_pc_o;
   logic [3:0]      cause_o;

   fwm_trap_seq #(.PC_W(PC_W), .SLOT_SH(SH)) u_dut (
      .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .fw_base_i(BASE),
      .instr_valid_i(instr_valid_i), .priv_op_i(priv_op_i),
      .unimpl_i(unimpl_i), .arith_i(arith_i), .mem_fault_i(mem_fault_i),
      .fw_call_i(fw_call_i), .itb_miss_i(itb_miss_i), .dtb_miss_i(dtb_miss_i),
      .irq_i(irq_i), .irq_en_i(irq_en_i),
      .redirect_o(redirect_o), .target_o(target_o), .cause_o(cause_o),
      .fw_mode_o(fw_mode_o), .xlate_on_o(xlate_on_o), .irq_allow_o(irq_allow_o),
      .priv_ok_o(priv_ok_o), .saved_pc_o(saved_pc_o), .saved_fw_o(saved_fw_o)
   );

   // Vector: pc[31:16], requests[15:8] = {irq,en,arith,unimpl,memf,call,itb,dtb},
   // op[7:5], expected cause[3:0] (0 = no redirect, 15 = return).
   function automatic logic [31:0] mk(input logic [15:0] p, input logic [7:0] r,
                                      input logic [2:0] o, input logic [3:0] c);
      return {p, r, o, 1'b0, c};
   endfunction

   localparam logic [31:0] VEC [NV] = '{
      mk(16'h0100, 8'h00, 3'd5, 4'hF), mk(16'h0200, 8'hC0, 3'd0, 4'h8),
      mk(16'h0210, 8'hC0, 3'd0, 4'h0), mk(16'h0220, 8'h00, 3'd5, 4'hF),
      mk(16'h0230, 8'h80, 3'd0, 4'h0), mk(16'h0300, 8'hFF, 3'd0, 4'h1),
      mk(16'h0304, 8'h00, 3'd5, 4'hF), mk(16'h0310, 8'hEF, 3'd0, 4'h2),
      mk(16'h0314, 8'h00, 3'd5, 4'hF), mk(16'h0320, 8'hCF, 3'd0, 4'h3),
      mk(16'h0324, 8'h00, 3'd5, 4'hF), mk(16'h0330, 8'hC7, 3'd0, 4'h4),
      mk(16'h0334, 8'h00, 3'd5, 4'hF), mk(16'h0340, 8'hC3, 3'd0, 4'h5),
      mk(16'h0344, 8'h00, 3'd5, 4'hF), mk(16'h0350, 8'hC1, 3'd0, 4'h6),
      mk(16'h0354, 8'h00, 3'd5, 4'hF), mk(16'h0360, 8'h00, 3'd1, 4'h1),
      mk(16'h0370, 8'h00, 3'd1, 4'h0), mk(16'h0374, 8'h00, 3'd2, 4'h0),
      mk(16'h0378, 8'h00, 3'd3, 4'h0), mk(16'h037C, 8'h00, 3'd4, 4'h0),
      mk(16'h0380, 8'h00, 3'd5, 4'hF), mk(16'h0390, 8'h00, 3'd2, 4'h1),
      mk(16'h0394, 8'h00, 3'd5, 4'hF), mk(16'h03A0, 8'h00, 3'd3, 4'h1),
      mk(16'h03A4, 8'h00, 3'd5, 4'hF), mk(16'h03B0, 8'h00, 3'd4, 4'h1),
      mk(16'h03B4, 8'h00, 3'd5, 4'hF), mk(16'h03C0, 8'h00, 3'd6, 4'h0),
      mk(16'h03C4, 8'h00, 3'd7, 4'h0), mk(16'h03D0, 8'h04, 3'd0, 4'h4),
      mk(16'h03E0, 8'h20, 3'd5, 4'h2), mk(16'h03E4, 8'h00, 3'd5, 4'hF),
      mk(16'h03F0, 8'h01, 3'd0, 4'h7), mk(16'h03F4, 8'h02, 3'd0, 4'h5)
   };

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input int idx, input logic [3:0] c);
      if (idx == 32) return "R9";
      if (idx == 35 || c == 4'h7) return "R8";
      case (c)
         4'hF: return "R7";
         4'h8: return "R5";
         4'h1: return "R6/R4";
         4'h0: return "R5/R6";
         default: return "R4";
      endcase
   endfunction

   task automatic clear_inputs();
      instr_valid_i = 1'b0; priv_op_i = 3'd0; unimpl_i = 1'b0; arith_i = 1'b0;
      mem_fault_i = 1'b0; fw_call_i = 1'b0; itb_miss_i = 1'b0; dtb_miss_i = 1'b0;
      irq_i = 1'b0; irq_en_i = 1'b0; pc_i = '0;
   endtask

   task automatic check_reset(input string tag);
      chk({tag, " fw_mode"},   32'(fw_mode_o),   32'd1);
      chk({tag, " xlate"},     32'(xlate_on_o),  32'd0);
      chk({tag, " irq_allow"}, 32'(irq_allow_o), 32'd0);
      chk({tag, " redirect"},  32'(redirect_o),  32'd0);
      chk({tag, " cause"},     32'(cause_o),     32'd0);
      chk({tag, " target"},    target_o,         32'd0);
      chk({tag, " saved_pc"},  saved_pc_o,       32'd0);
      chk({tag, " saved_fw"},  32'(saved_fw_o),  32'd0);
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic            m_fw, m_sfw;
      logic [PC_W-1:0] m_spc, m_tgt, hold_pc;
      logic            hold_fw, hold_sfw;

      rst_n = 1'b0;
      clear_inputs();
      repeat (3) @(posedge clk);
      #1;
      check_reset("R1 reset");
      @(negedge clk);
      rst_n = 1'b1;
      m_fw = 1'b1; m_sfw = 1'b0; m_spc = '0; m_tgt = '0;

      for (int v = 0; v < NV; v++) begin
         logic [31:0] e;
         logic [3:0]  ec;
         string       t;
         e  = VEC[v];
         ec = e[3:0];
         t  = tag_of(v, ec);
         @(negedge clk);
         pc_i          = {16'h0, e[31:16]};
         irq_i         = e[15];
         irq_en_i      = e[14];
         arith_i       = e[13];
         unimpl_i      = e[12];
         mem_fault_i   = e[11];
         fw_call_i     = e[10];
         itb_miss_i    = e[9];
         dtb_miss_i    = e[8];
         priv_op_i     = e[7:5];
         instr_valid_i = 1'b1;
         #1;
         chk("R6 priv_ok", 32'(priv_ok_o),
             32'((e[7:5] >= 3'd1) && (e[7:5] <= 3'd5) && m_fw));
         @(posedge clk);
         #1;
         // Reference update from the requirements.
         if (ec == 4'hF) begin
            m_tgt = m_spc;
            m_fw  = m_sfw;
         end else if (ec != 4'h0) begin
            m_tgt = BASE + (32'(ec) << SH);
            m_spc = pc_i;
            m_sfw = m_fw;
            m_fw  = 1'b1;
         end
         chk({t, " redirect"}, 32'(redirect_o), 32'(ec != 4'h0));
         chk({t, " cause"},    32'(cause_o),    32'(ec));
         if (ec != 4'h0) chk("R3 target", target_o, m_tgt);
         chk("R2 fw_mode",   32'(fw_mode_o),   32'(m_fw));
         chk("R2 xlate",     32'(xlate_on_o),  32'(!m_fw));
         chk("R2 irq_allow", 32'(irq_allow_o), 32'(!m_fw));
         chk("R2 saved_pc",  saved_pc_o,       m_spc);
         chk("R2 saved_fw",  32'(saved_fw_o),  32'(m_sfw));
      end

      // R10: idle cycles hold state and drop the strobe
      @(negedge clk);
      clear_inputs();
      hold_pc = saved_pc_o; hold_fw = fw_mode_o; hold_sfw = saved_fw_o;
      for (int k = 0; k < 2; k++) begin
         @(posedge clk);
         #1;
         chk("R10 redirect", 32'(redirect_o),  32'd0);
         chk("R10 cause",    32'(cause_o),     32'd0);
         chk("R10 fw_mode",  32'(fw_mode_o),   32'(hold_fw));
         chk("R10 saved_pc", saved_pc_o,       hold_pc);
         chk("R10 saved_fw", 32'(saved_fw_o),  32'(hold_sfw));
      end

      // R1: reset applied mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      check_reset("R1 mid-run reset");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule